// File: doc/BRIEF.md
# Oversampled Serial Receiver with One-and-a-Half Stop Bits

This block receives asynchronous serial characters on a single line. It uses a clock enable that pulses sixteen times per bit period. The character format is selectable: five to eight data bits, an optional even-parity bit, and a stop-length select. The long stop setting gives one and a half stop bits. That setting only applies to five-bit words without parity. With any other format the receiver treats the select as asking for a single stop bit.

A completed character goes into a holding register, which sets a full flag and raises an interrupt. In the normal formats this happens at the centre of the first stop bit. In the one-and-a-half-stop format it happens halfway through the trailing half stop bit.

An input reports that the modem has lost carrier. While it is high, the receiver stays idle and the interrupt output is held low. The host reads the held character by pulsing a read strobe, which clears the flag and the interrupt.

Top module: `frac_stop_rx`

## Requirements
- R1: With the line held high (mark), the receiver never sets the full flag or raises the interrupt.
- R2: A low level on the line is taken as a start bit only if the line is still low at the eighth oversampling tick after the tick that first saw it low. Otherwise the receiver returns to idle and loads nothing.
- R3: Data bits are sampled every sixteen ticks after the start-bit centre and assembled least significant bit first. The word length select encodes 0, 1, 2 and 3 as 5, 6, 7 and 8 bits. Data bits above the word length read as zero.
- R4: In the normal formats, the full flag and the interrupt rise on the tick that samples the centre of the first stop bit. Counting the first tick that sees the start bit low as tick 1, that is tick 9 + 16·(bits + parity + 1).
- R5: The one-and-a-half stop setting takes effect only with a 5-bit word and parity disabled. With any other format, stop select = 1 gives the single-stop timing of R4.
- R6: In the one-and-a-half stop format, the full flag and the interrupt rise 12 ticks after the stop-bit centre sample. That point is 1.25 bit times after the stop period begins.
- R7: While the carrier-lost input is high, the interrupt output is low and no new character is received. A character already held keeps its full flag, and its interrupt returns when carrier comes back.
- R8: A stop bit sampled low sets the framing-error flag, and the character's data is still loaded.
- R9: If a character completes while the full flag is set, the overrun flag is set and the held data is kept unchanged.
- R10: A read strobe clears the full flag, the interrupt and the overrun flag on the next clock edge.
- R11: With parity enabled, the parity-error flag is set when data bits plus the parity bit contain an odd number of ones (even parity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| word_len | input | 2 | Word length: 0=5, 1=6, 2=7, 3=8 bits |
| parity_on | input | 1 | Enables an even-parity bit after the data |
| long_stop | input | 1 | Requests one and a half stop bits (5-bit, no parity only) |
| carrier_lost | input | 1 | High while the modem reports no carrier |
| data_read | input | 1 | One-cycle strobe: host reads the held character |
| rx_data | output | 8 | Held character, right-aligned |
| rx_full | output | 1 | A character is waiting to be read |
| rx_irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Stop bit of the held character was low |
| parity_err | output | 1 | Parity of the held character was wrong |
| overrun | output | 1 | A character was lost because the register was full |

## Verification
The bench sweeps all sixteen format combinations and measures the tick at which the full flag rises against the arithmetic expectation. A receiver that applied the long stop to a wider word, or that placed the interrupt at the stop centre in five-bit mode, shows up as an arrival twelve ticks off. Short low pulses check that a glitch is dropped rather than loaded as a character of zeros. A frame sent with carrier lost, and a held character whose carrier drops, check that the receive gate and the interrupt mask act separately. Back-to-back characters without a read check that the second one cannot overwrite the first.

// File: rtl/frac_stop_rx_pkg.sv
package frac_stop_rx_pkg;

    localparam int DATA_W    = 8;
    localparam int OVS       = 16;
    localparam int CNT_W     = $clog2(OVS);
    localparam int BIT_IDX_W = $clog2(DATA_W);

    // Tick counts (minus one) for each timed interval
    localparam logic [CNT_W-1:0] START_CHECK = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_SPAN    = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_TAIL   = CNT_W'((OVS * 3) / 4 - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HALF
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       long_stop;
    } rx_fmt_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              par_err;
    } rx_char_t;

    function automatic int unsigned word_bits(input logic [1:0] wlen);
        return 5 + int'(wlen);
    endfunction

    function automatic logic half_stop_mode(input rx_fmt_t f);
        return f.long_stop && (f.wlen == 2'd0) && !f.par_en;
    endfunction

    function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] sh,
                                                     input logic [1:0] wlen);
        return sh >> (DATA_W - word_bits(wlen));
    endfunction

endpackage

// File: rtl/fsr_tick_timer.sv
module fsr_tick_timer
    import frac_stop_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fsr_frame_ctrl.sv
module fsr_frame_ctrl
    import frac_stop_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line,
    input  logic             carrier_lost,
    input  rx_fmt_t          fmt,
    input  logic [CNT_W-1:0] cnt,
    output logic             tmr_clr,
    output logic             done,
    output rx_char_t         chr
);

    rx_state_e             st_q, st_d;
    logic [BIT_IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0]     shreg_q;
    logic                  par_acc_q;
    logic                  stop_ok_q;
    logic                  samp_data;
    logic                  samp_par;
    logic                  enter_start;
    logic                  enter_half;
    logic [BIT_IDX_W-1:0]  last_idx;

    assign last_idx = BIT_IDX_W'(word_bits(fmt.wlen) - 1);

    always_comb begin
        st_d        = st_q;
        tmr_clr     = 1'b0;
        done        = 1'b0;
        samp_data   = 1'b0;
        samp_par    = 1'b0;
        enter_start = 1'b0;
        enter_half  = 1'b0;
        if (carrier_lost) begin
            st_d    = ST_IDLE;
            tmr_clr = 1'b1;
        end else if (tick) begin
            case (st_q)
                ST_IDLE: begin
                    if (!line) begin
                        st_d        = ST_START;
                        tmr_clr     = 1'b1;
                        enter_start = 1'b1;
                    end
                end
                ST_START: begin
                    if (cnt == START_CHECK) begin
                        tmr_clr = 1'b1;
                        st_d    = line ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (cnt == BIT_SPAN) begin
                        tmr_clr   = 1'b1;
                        samp_data = 1'b1;
                        if (bit_idx_q == last_idx) begin
                            st_d = fmt.par_en ? ST_PAR : ST_STOP;
                        end
                    end
                end
                ST_PAR: begin
                    if (cnt == BIT_SPAN) begin
                        tmr_clr  = 1'b1;
                        samp_par = 1'b1;
                        st_d     = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (cnt == BIT_SPAN) begin
                        tmr_clr = 1'b1;
                        if (half_stop_mode(fmt)) begin
                            st_d       = ST_HALF;
                            enter_half = 1'b1;
                        end else begin
                            st_d = ST_IDLE;
                            done = 1'b1;
                        end
                    end
                end
                ST_HALF: begin
                    if (cnt == HALF_TAIL) begin
                        tmr_clr = 1'b1;
                        st_d    = ST_IDLE;
                        done    = 1'b1;
                    end
                end
                default: begin
                    st_d    = ST_IDLE;
                    tmr_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            stop_ok_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (enter_start) begin
                bit_idx_q <= '0;
                par_acc_q <= 1'b0;
            end
            if (samp_data) begin
                shreg_q   <= {line, shreg_q[DATA_W-1:1]};
                par_acc_q <= par_acc_q ^ line;
                bit_idx_q <= bit_idx_q + 1'b1;
            end
            if (samp_par) begin
                par_acc_q <= par_acc_q ^ line;
            end
            if (enter_half) begin
                stop_ok_q <= line;
            end
        end
    end

    always_comb begin
        chr.data      = align_word(shreg_q, fmt.wlen);
        chr.frame_err = (st_q == ST_HALF) ? !stop_ok_q : !line;
        chr.par_err   = fmt.par_en && par_acc_q;
    end

    AST_CARRIER_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        carrier_lost |=> (st_q == ST_IDLE)); // R7

    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START && tick && !carrier_lost && cnt == START_CHECK && line)
        |=> (st_q == ST_IDLE)); // R2

    AST_HALF_ONLY_SHORT_WORD: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALF) |-> (fmt.wlen == 2'd0 && !fmt.par_en)); // R5

endmodule

// File: rtl/fsr_hold_reg.sv
module fsr_hold_reg
    import frac_stop_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  rx_fmt_t           fmt,
    input  logic              rd,
    input  logic              carrier_lost,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              irq,
    output logic              ferr,
    output logic              perr,
    output logic              ovr
);

    logic full_eff;

    assign full_eff = full && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            ferr <= 1'b0;
            perr <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (done) begin
                if (full_eff) begin
                    ovr <= 1'b1;
                end else begin
                    data <= chr.data;
                    ferr <= chr.frame_err;
                    perr <= chr.par_err;
                    full <= 1'b1;
                end
            end
        end
    end

    assign irq = full && !carrier_lost;

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (full && done && !rd) |=> ($stable(data) && ovr)); // R9

    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> (!full && !ovr)); // R10

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> ((data >> word_bits(fmt.wlen)) == '0)); // R3

endmodule

// File: rtl/frac_stop_rx.sv
module frac_stop_rx
    import frac_stop_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic [1:0]        word_len,
    input  logic              parity_on,
    input  logic              long_stop,
    input  logic              carrier_lost,
    input  logic              data_read,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun
);

    logic             line_s;
    logic [CNT_W-1:0] cnt;
    logic             tmr_clr;
    logic             done;
    rx_char_t         chr;
    rx_fmt_t          fmt;

    assign fmt = '{wlen: word_len, par_en: parity_on, long_stop: long_stop};

    generate
        if (SYNC_STAGES <= 1) begin : g_sync_one
            logic sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= 1'b1;
                else     sync_q <= rx_line;
            end
            assign line_s = sync_q;
        end else begin : g_sync_chain
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
            end
            assign line_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    fsr_tick_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick16),
        .clr  (tmr_clr),
        .cnt  (cnt)
    );

    fsr_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick16),
        .line         (line_s),
        .carrier_lost (carrier_lost),
        .fmt          (fmt),
        .cnt          (cnt),
        .tmr_clr      (tmr_clr),
        .done         (done),
        .chr          (chr)
    );

    fsr_hold_reg u_hold (
        .clk          (clk),
        .rst          (rst),
        .done         (done),
        .chr          (chr),
        .fmt          (fmt),
        .rd           (data_read),
        .carrier_lost (carrier_lost),
        .data         (rx_data),
        .full         (rx_full),
        .irq          (rx_irq),
        .ferr         (frame_err),
        .perr         (parity_err),
        .ovr          (overrun)
    );

    AST_MARK_NO_COMPLETION: assert property (@(posedge clk) disable iff (rst)
        (line_s && $past(line_s) && !rx_full && !data_read && !tick16) |=> !rx_full); // R1

endmodule

// File: tb/frac_stop_rx_bench.sv
module frac_stop_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_on = 1'b0;
    logic       long_stop = 1'b0;
    logic       carrier_lost = 1'b0;
    logic       data_read = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_irq, frame_err, parity_err, overrun;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int rise_tick = -1;
    int base_tick = 0;
    logic prev_full = 1'b0;
    logic [1:0] div = 2'd0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    frac_stop_rx u_frac_stop_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line), .tick16(tick16),
        .word_len(word_len), .parity_on(parity_on), .long_stop(long_stop),
        .carrier_lost(carrier_lost), .data_read(data_read),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun)
    );

    always @(negedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    always @(posedge clk) if (tick16) tick_cnt <= tick_cnt + 1;

    always @(negedge clk) begin
        if (rx_full && !prev_full) rise_tick = tick_cnt;
        prev_full = rx_full;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int target = tick_cnt + n;
        while (tick_cnt < target) @(negedge clk);
    endtask

    function automatic int nbits();
        return 5 + int'(word_len);
    endfunction

    function automatic bit frac_mode();
        return long_stop && word_len == 2'd0 && !parity_on;
    endfunction

    function automatic int expected_rise();
        return 9 + 16 * (nbits() + (parity_on ? 1 : 0) + 1) + (frac_mode() ? 12 : 0);
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit bad_stop, input bit bad_par);
        logic [7:0] m;
        m = d & 8'((1 << nbits()) - 1);
        @(negedge clk);
        while (!tick16) @(negedge clk);
        @(negedge clk);
        base_tick = tick_cnt;
        rise_tick = -1;
        rx_line = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < nbits(); i++) begin
            rx_line = m[i];
            wait_ticks(16);
        end
        if (parity_on) begin
            rx_line = (^m) ^ bad_par;
            wait_ticks(16);
        end
        if (bad_stop) begin
            rx_line = 1'b0;
            wait_ticks(12);
            rx_line = 1'b1;
            wait_ticks(frac_mode() ? 12 : 4);
        end else begin
            rx_line = 1'b1;
            wait_ticks(frac_mode() ? 24 : 16);
        end
        wait_ticks(4);
    endtask

    task automatic do_read();
        @(negedge clk);
        data_read = 1'b1;
        @(negedge clk);
        data_read = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1..: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] vals [3];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset full", rx_full, 0);
        check("R10 reset irq", rx_irq, 0);
        check("R3 reset data", rx_data, 0);

        // R1: continuous mark
        wait_ticks(200);
        check("R1 mark full", rx_full, 0);
        check("R1 mark irq", rx_irq, 0);

        // Sweep of all formats: R3 R4 R5 R6
        for (int cfg = 0; cfg < 16; cfg++) begin
            word_len  = cfg[1:0];
            parity_on = cfg[2];
            long_stop = cfg[3];
            vals[0] = 8'hA5;
            vals[1] = 8'h5A ^ 8'(cfg * 7);
            vals[2] = 8'hFF;
            for (int v = 0; v < 3; v++) begin
                send_frame(vals[v], 1'b0, 1'b0);
                check("R3 data", rx_data, vals[v] & 8'((1 << nbits()) - 1));
                if (frac_mode())
                    check("R6 half-stop timing", rise_tick - base_tick, expected_rise());
                else if (long_stop)
                    check("R5 long stop ignored timing", rise_tick - base_tick, expected_rise());
                else
                    check("R4 stop-centre timing", rise_tick - base_tick, expected_rise());
                check("R4 irq", rx_irq, 1);
                check("R8 no frame err", frame_err, 0);
                check("R11 no parity err", parity_err, 0);
                do_read();
                check("R10 read clears full", rx_full, 0);
                check("R10 read clears irq", rx_irq, 0);
            end
        end

        // R2: glitch shorter than half a bit
        word_len = 2'd3; parity_on = 1'b0; long_stop = 1'b0;
        @(negedge clk);
        rx_line = 1'b0;
        wait_ticks(3);
        rx_line = 1'b1;
        wait_ticks(200);
        check("R2 glitch not loaded", rx_full, 0);
        send_frame(8'h3C, 1'b0, 1'b0);
        check("R2 frame after glitch", rx_data, 8'h3C);
        do_read();

        // R8: framing error, data still loaded (also in long-stop mode)
        send_frame(8'hC3, 1'b1, 1'b0);
        check("R8 frame err flag", frame_err, 1);
        check("R8 data loaded", rx_data, 8'hC3);
        do_read();
        word_len = 2'd0; long_stop = 1'b1;
        send_frame(8'h15, 1'b1, 1'b0);
        check("R8 frame err half-stop", frame_err, 1);
        check("R8 data half-stop", rx_data, 8'h15);
        do_read();

        // R11: parity error
        word_len = 2'd2; parity_on = 1'b1; long_stop = 1'b0;
        send_frame(8'h2B, 1'b0, 1'b1);
        check("R11 parity err", parity_err, 1);
        check("R11 data", rx_data, 8'h2B);
        do_read();
        send_frame(8'h2B, 1'b0, 1'b0);
        check("R11 parity ok", parity_err, 0);
        do_read();

        // R9: overrun
        word_len = 2'd3; parity_on = 1'b0;
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);
        check("R9 overrun flag", overrun, 1);
        check("R9 old data kept", rx_data, 8'h11);
        do_read();
        check("R10 overrun cleared", overrun, 0);
        check("R10 full cleared", rx_full, 0);

        // R7: carrier lost
        carrier_lost = 1'b1;
        send_frame(8'h77, 1'b0, 1'b0);
        check("R7 no receive without carrier", rx_full, 0);
        check("R7 no irq without carrier", rx_irq, 0);
        carrier_lost = 1'b0;
        send_frame(8'h66, 1'b0, 1'b0);
        check("R7 receive after carrier", rx_data, 8'h66);
        check("R7 irq after carrier", rx_irq, 1);
        carrier_lost = 1'b1;
        @(negedge clk);
        check("R7 irq masked", rx_irq, 0);
        check("R7 full kept", rx_full, 1);
        carrier_lost = 1'b0;
        @(negedge clk);
        check("R7 irq returns", rx_irq, 1);
        do_read();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule